// File: doc/BRIEF.md
# Serial Configuration Register Controller

This block is the digital control core of a multi-channel amplifier front end. A host writes configuration words through a three-wire serial port: an active-low enable, a serial clock and a data line. The block keeps three small control registers and decodes them into the signals that steer the analog path. These signals are a six-line thermometer word that closes the attenuator shunt switches, a filter bandwidth select, and partial and complete power-down controls. A separate readback mode shifts a selected register out on a serial output line so the host can confirm that its writes arrived.

The serial pins are sampled by a faster system clock, which must run at least four times the serial clock rate. Every serial pin passes through a two-flop synchronizer before use. A hardware reset pin clears the registers. While that pin stays high, the block ignores the serial port, and the parallel gain pins and the level of the data pin set the gain and the bandwidth instead. An active-high power-down pin adds a partial power-down on top of the register setting.

Top module: `sercfg_ctrl`

## Requirements
- R1: Bits are taken only on rising edges of `ser_clk` while `ser_en_n` is low. Each word is 24 bits, sent most significant bit first: an 8-bit address followed by 16 data bits.
- R2: Raising `ser_en_n` drops any bits collected so far. A word left shorter than 24 bits changes nothing, and the next enable window starts counting from its first bit.
- R3: Every 24th rising edge inside one enable window applies a complete word. Several words can therefore be loaded back to back without raising the enable.
- R4: `shunt_on` is a thermometer word. Gain code k (0 to 6) closes the k lowest lines, starting at bit 0. Code 7 closes all six lines.
- R5: Register 0x3B sets `bw_low` from data bit 7 and the gain code from bits 6:4. Register 0x35 sets `pd_complete` from bit 15 and the partial power-down from bit 14.
- R6: A word to register 0x00 with data bit 0 set returns every register to zero. That bit never stays set, so it reads back as 0.
- R7: Data bit 1 of register 0x00 selects readout mode. In this mode a word only selects a register, and its data bits are not written. The exception is register 0x00, which still accepts writes. The selected register's 16 bits appear on `ser_dout`, most significant bit first, updated after each falling `ser_clk` edge of the data phase. Unlisted addresses read back as zero. Outside the data phase, `ser_dout` is low.
- R8: While `hw_rst` is high, all registers are held at zero and serial words are ignored. During that time the gain code comes from `gain_pin` and `bw_low` follows the level of `ser_din`.
- R9: `pd_partial` is high whenever `pdn_pin` is high or the partial power-down register bit is set. Power-down does not change the register contents.
- R10: Words addressed to any register other than 0x00, 0x35 and 0x3B change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Active-low system reset |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data; bandwidth strap in pin mode |
| hw_rst | input | 1 | Hardware reset and pin-mode select, active high |
| pdn_pin | input | 1 | Partial power-down request, active high |
| gain_pin | input | 3 | Gain code used in pin mode |
| ser_dout | output | 1 | Serial readback data |
| shunt_on | output | 6 | Attenuator shunt switch enables, thermometer coded |
| bw_low | output | 1 | Low bandwidth select |
| pd_partial | output | 1 | Partial power-down control |
| pd_complete | output | 1 | Complete power-down control |

## Verification
Two actions can land in the same system cycle: a word completes on its 24th edge while the hardware reset is high. The bench provokes this by raising `hw_rst` partway through a word that sets complete power-down, then finishing the word. It judges the outcome by requiring that `pd_complete` stays low both during pin mode and after release. In a second case, a readback shift and a register-0x00 write share one word, and the bench checks that the shifted-out bits match the register value from before the write.

// File: rtl/sercfg_pkg.sv
package sercfg_pkg;
  localparam int FRAME_BITS = 24;
  localparam int ADDR_BITS  = 8;
  localparam int DATA_BITS  = 16;
  localparam int SHUNTS     = 6;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  localparam logic [ADDR_BITS-1:0] ADR_CTRL = 8'h00;
  localparam logic [ADDR_BITS-1:0] ADR_PWR  = 8'h35;
  localparam logic [ADDR_BITS-1:0] ADR_FILT = 8'h3B;

  typedef struct packed {
    logic       ro_en;
    logic       pd_full;
    logic       pd_part;
    logic       bw_low;
    logic [2:0] gain;
  } cfg_t;

  // gain code k closes the k lowest shunt lines; codes past SHUNTS close all
  function automatic logic [SHUNTS-1:0] gain_to_shunts(input logic [2:0] code);
    logic [SHUNTS-1:0] t;
    t = '0;
    for (int i = 0; i < SHUNTS; i++)
      if (int'(code) > i) t[i] = 1'b1;
    return t;
  endfunction

  function automatic logic [DATA_BITS-1:0] read_word(input cfg_t c,
                                                      input logic [ADDR_BITS-1:0] a);
    logic [DATA_BITS-1:0] w;
    w = '0;
    case (a)
      ADR_CTRL: w[1] = c.ro_en;
      ADR_PWR:  begin w[15] = c.pd_full; w[14] = c.pd_part; end
      ADR_FILT: begin w[7] = c.bw_low; w[6:4] = c.gain; end
      default:  w = '0;
    endcase
    return w;
  endfunction
endpackage

// File: rtl/sercfg_sync.sv
module sercfg_sync #(
  parameter int          W       = 8,
  parameter int          STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/sercfg_frame_rx.sv
module sercfg_frame_rx
  import sercfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_s,
  input  logic                  en_n_s,
  input  logic                  din_s,
  output logic                  sclk_fall,
  output logic                  frame_done,
  output logic [FRAME_BITS-1:0] frame_word,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic [ADDR_BITS-1:0]  addr_now
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_BITS - 1);

  logic                  sclk_d;
  logic                  sclk_rise;
  logic [FRAME_BITS-1:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d <= 1'b0;
    else        sclk_d <= sclk_s;
  end

  assign sclk_rise = sclk_s & ~sclk_d;
  assign sclk_fall = ~sclk_s & sclk_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_cnt    <= '0;
      sh         <= '0;
      frame_done <= 1'b0;
      frame_word <= '0;
    end else begin
      frame_done <= 1'b0;
      if (en_n_s) begin
        bit_cnt <= '0;
      end else if (sclk_rise) begin
        sh <= {sh[FRAME_BITS-2:0], din_s};
        if (bit_cnt == LAST) begin
          bit_cnt    <= '0;
          frame_done <= 1'b1;
          frame_word <= {sh[FRAME_BITS-2:0], din_s};
        end else begin
          bit_cnt <= bit_cnt + 1'b1;
        end
      end
    end
  end

  assign addr_now = sh[ADDR_BITS-1:0];

  // R2: a raised enable leaves the counter at the frame start
  p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_s |=> (bit_cnt == '0));
  // R3: a word completes only on a qualified rising serial edge
  p_done_on_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(sclk_rise) && !$past(en_n_s)));
  // R1: the count never runs past one frame
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= LAST);
endmodule

// File: rtl/sercfg_regs.sv
module sercfg_regs
  import sercfg_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  hw_rst_s,
  input  logic                  en_n_s,
  input  logic                  sclk_fall,
  input  logic                  frame_done,
  input  logic [FRAME_BITS-1:0] frame_word,
  input  logic [CNT_W-1:0]      bit_cnt,
  input  logic [ADDR_BITS-1:0]  addr_now,
  output cfg_t                  cfg,
  output logic                  ser_dout
);
  logic [ADDR_BITS-1:0] f_addr;
  logic [DATA_BITS-1:0] f_data;
  logic                 wr_ok;
  logic                 listed;
  logic [DATA_BITS-1:0] rd_val;
  logic [DATA_BITS-1:0] rd_sh;

  assign f_addr = frame_word[FRAME_BITS-1:DATA_BITS];
  assign f_data = frame_word[DATA_BITS-1:0];
  assign wr_ok  = frame_done && !hw_rst_s && (!cfg.ro_en || f_addr == ADR_CTRL);
  assign listed = (f_addr == ADR_CTRL) || (f_addr == ADR_PWR) || (f_addr == ADR_FILT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (hw_rst_s) begin
      cfg <= '0;
    end else if (wr_ok) begin
      case (f_addr)
        ADR_CTRL: begin
          if (f_data[0]) cfg <= '0;
          else           cfg.ro_en <= f_data[1];
        end
        ADR_PWR: begin
          cfg.pd_full <= f_data[15];
          cfg.pd_part <= f_data[14];
        end
        ADR_FILT: begin
          cfg.bw_low <= f_data[7];
          cfg.gain   <= f_data[6:4];
        end
        default: ;
      endcase
    end
  end

  assign rd_val = read_word(cfg, addr_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ser_dout <= 1'b0;
      rd_sh    <= '0;
    end else if (en_n_s || !cfg.ro_en) begin
      ser_dout <= 1'b0;
    end else if (sclk_fall) begin
      if (bit_cnt == CNT_W'(ADDR_BITS)) begin
        ser_dout <= rd_val[DATA_BITS-1];
        rd_sh    <= {rd_val[DATA_BITS-2:0], 1'b0};
      end else if (bit_cnt > CNT_W'(ADDR_BITS)) begin
        ser_dout <= rd_sh[DATA_BITS-1];
        rd_sh    <= {rd_sh[DATA_BITS-2:0], 1'b0};
      end else begin
        ser_dout <= 1'b0;
      end
    end
  end

  // R8: hardware reset holds every register at zero
  p_hw_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hw_rst_s |=> (cfg == '0));
  // R6: software reset clears all registers including itself
  p_swrst_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !hw_rst_s && f_addr == ADR_CTRL && f_data[0]) |=> (cfg == '0));
  // R7: in readout mode only register 0x00 can be written
  p_ro_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.ro_en && frame_done && f_addr != ADR_CTRL && !hw_rst_s) |=> $stable(cfg));
  // R7: readback line idles low while the enable is high
  p_dout_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_n_s |=> !ser_dout);
  // R10: unlisted addresses leave the registers alone
  p_unlisted_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !listed && !hw_rst_s) |=> $stable(cfg));
endmodule

// File: rtl/sercfg_ctrl.sv
module sercfg_ctrl
  import sercfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_en_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              hw_rst,
  input  logic              pdn_pin,
  input  logic [2:0]        gain_pin,
  output logic              ser_dout,
  output logic [SHUNTS-1:0] shunt_on,
  output logic              bw_low,
  output logic              pd_partial,
  output logic              pd_complete
);
  localparam int PINS = 8;
  localparam logic [PINS-1:0] PIN_RST = 8'b0000_0100;   // enable idles high

  logic [PINS-1:0]       pins_s;
  logic                  hw_s, pdn_s, en_n_s, sclk_s, din_s;
  logic [2:0]            gain_s;
  logic                  sclk_fall, frame_done;
  logic [FRAME_BITS-1:0] frame_word;
  logic [CNT_W-1:0]      bit_cnt;
  logic [ADDR_BITS-1:0]  addr_now;
  cfg_t                  cfg;
  logic [2:0]            gain_sel;

  sercfg_sync #(.W(PINS), .STAGES(2), .RST_VAL(PIN_RST)) i_sync (
    .clk(clk), .rst_n(rst_n),
    .d({hw_rst, pdn_pin, gain_pin, ser_en_n, ser_clk, ser_din}),
    .q(pins_s));

  assign {hw_s, pdn_s, gain_s, en_n_s, sclk_s, din_s} = pins_s;

  sercfg_frame_rx i_rx (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .en_n_s(en_n_s), .din_s(din_s),
    .sclk_fall(sclk_fall), .frame_done(frame_done), .frame_word(frame_word),
    .bit_cnt(bit_cnt), .addr_now(addr_now));

  sercfg_regs i_regs (
    .clk(clk), .rst_n(rst_n), .hw_rst_s(hw_s), .en_n_s(en_n_s),
    .sclk_fall(sclk_fall), .frame_done(frame_done), .frame_word(frame_word),
    .bit_cnt(bit_cnt), .addr_now(addr_now), .cfg(cfg), .ser_dout(ser_dout));

  assign gain_sel    = hw_s ? gain_s : cfg.gain;
  assign shunt_on    = gain_to_shunts(gain_sel);
  assign bw_low      = hw_s ? din_s : cfg.bw_low;
  assign pd_partial  = cfg.pd_part | pdn_s;
  assign pd_complete = cfg.pd_full;

  // R4: shunt word is always a thermometer code
  p_thermo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({1'b0, shunt_on} + 7'd1));
  // R9: the power-down pin always reaches partial power-down
  p_pdn_force_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pdn_s |-> pd_partial);
  // R8: complete power-down cannot be set in pin mode
  p_pin_mode_pd_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hw_s) |-> !pd_complete);
endmodule

// File: tb/test_sercfg_ctrl.sv
`timescale 1ns/1ps
module test_sercfg_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_en_n = 1'b1, ser_clk = 1'b0, ser_din = 1'b0;
  logic       hw_rst = 1'b0, pdn_pin = 1'b0;
  logic [2:0] gain_pin = 3'd0;
  logic       ser_dout;
  logic [5:0] shunt_on;
  logic       bw_low, pd_partial, pd_complete;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  bit m_ro, m_pf, m_pp, m_bw;
  logic [2:0] m_gain;

  always #2.5 clk = ~clk;

  sercfg_ctrl i_sercfg_ctrl (
    .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .hw_rst(hw_rst), .pdn_pin(pdn_pin), .gain_pin(gain_pin),
    .ser_dout(ser_dout), .shunt_on(shunt_on), .bw_low(bw_low),
    .pd_partial(pd_partial), .pd_complete(pd_complete));

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] exp_shunts(input logic [2:0] code);
    int n;
    n = (code > 3'd6) ? 6 : int'(code);
    return 6'((7'd1 << n) - 7'd1);
  endfunction

  function automatic logic [15:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return {14'd0, m_ro, 1'b0};
    if (a == 8'h35) return {m_pf, m_pp, 14'd0};
    if (a == 8'h3B) return {8'd0, m_bw, m_gain, 4'd0};
    return 16'd0;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [15:0] d);
    if (hw_rst) return;
    if (m_ro && a != 8'h00) return;
    case (a)
      8'h00: if (d[0]) begin m_ro = 0; m_pf = 0; m_pp = 0; m_bw = 0; m_gain = 0; end
             else m_ro = d[1];
      8'h35: begin m_pf = d[15]; m_pp = d[14]; end
      8'h3B: begin m_bw = d[7]; m_gain = d[6:4]; end
      default: ;
    endcase
  endtask

  task automatic check_outs(input string req);
    logic [2:0] g;
    g = hw_rst ? gain_pin : m_gain;
    check({req, " shunt"}, 32'(shunt_on), 32'(exp_shunts(g)));
    check({req, " bw"}, 32'(bw_low), 32'(hw_rst ? ser_din : m_bw));
    check({req, " pdp"}, 32'(pd_partial), 32'(m_pp | pdn_pin));
    check({req, " pdc"}, 32'(pd_complete), 32'(m_pf));
  endtask

  // one serial bit; optional readback check in the low phase
  task automatic send_bit(input logic b, input int idx, input bit chk, input logic [15:0] rexp);
    ser_clk = 1'b0;
    ser_din = b;
    cyc(8);
    if (chk) begin
      if (idx >= 8) check("R7 readback bit", 32'(ser_dout), 32'(rexp[23-idx]));
      else          check("R7 dout idle in address", 32'(ser_dout), 32'd0);
    end
    ser_clk = 1'b1;
    cyc(8);
  endtask

  task automatic send_word(input logic [7:0] a, input logic [15:0] d, input bit chk,
                           input logic [15:0] rexp);
    logic [23:0] w;
    w = {a, d};
    for (int i = 0; i < 24; i++) send_bit(w[23-i], i, chk, rexp);
  endtask

  task automatic close_window();
    ser_clk = 1'b0;
    cyc(4);
    ser_en_n = 1'b1;
    ser_din = 1'b0;
    cyc(10);
  endtask

  task automatic frame(input logic [7:0] a, input logic [15:0] d);
    ser_en_n = 1'b0;
    cyc(4);
    send_word(a, d, 0, 16'd0);
    close_window();
    model_write(a, d);
  endtask

  task automatic read_frame(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] e;
    e = exp_read(a);
    ser_en_n = 1'b0;
    cyc(4);
    send_word(a, d, 1, e);
    close_window();
    model_write(a, d);
  endtask

  initial begin
    m_ro = 0; m_pf = 0; m_pp = 0; m_bw = 0; m_gain = 0;
    cyc(5);
    rst_n = 1'b1;
    cyc(5);
    check_outs("R8 reset state");
    check("R7 reset dout", 32'(ser_dout), 32'd0);

    // R5 R4: directed writes across all gain codes
    for (int g = 0; g < 8; g++) begin
      frame(8'h3B, 16'(g << 4) | 16'h0080);
      check_outs("R4 R5 gain sweep");
    end
    frame(8'h35, 16'hC000);
    check_outs("R5 power regs");

    // R9: pin forces partial power-down; contents kept
    frame(8'h35, 16'h8000);
    pdn_pin = 1'b1; cyc(6);
    check_outs("R9 pdn pin on");
    pdn_pin = 1'b0; cyc(6);
    check_outs("R9 pdn pin off, regs kept");

    // R3: two words in one window, trailing bits dropped
    ser_en_n = 1'b0; cyc(4);
    send_word(8'h3B, 16'h0050, 0, 16'd0);
    send_word(8'h35, 16'h4000, 0, 16'd0);
    for (int i = 0; i < 5; i++) send_bit(1'b1, i, 0, 16'd0);
    close_window();
    model_write(8'h3B, 16'h0050);
    model_write(8'h35, 16'h4000);
    check_outs("R3 back-to-back words");

    // R2: partial word discarded, next window realigned
    ser_en_n = 1'b0; cyc(4);
    for (int i = 0; i < 10; i++) send_bit((i == 2 || i == 4 || i == 5 || i == 7) ? 1'b1 : 1'b0, i, 0, 16'd0);
    close_window();
    check_outs("R2 partial word ignored");
    frame(8'h3B, 16'h0030);
    check_outs("R2 R1 realigned word");

    // R10: unlisted address
    frame(8'h36, 16'hFFFF);
    frame(8'h3A, 16'hFFFF);
    check_outs("R10 unlisted write ignored");

    // R7: readout mode
    frame(8'h00, 16'h0002);
    read_frame(8'h3B, 16'h0000);
    read_frame(8'h35, 16'h0000);
    read_frame(8'h77, 16'h0000);
    read_frame(8'h35, 16'hC000);   // write in readout mode ignored
    check_outs("R7 readout locks registers");
    read_frame(8'h35, 16'h0000);
    read_frame(8'h00, 16'h0000);   // shifts old value and leaves readout mode
    check("R7 readout exit dout", 32'(ser_dout), 32'd0);
    frame(8'h3B, 16'h00A0);
    check_outs("R7 writes restored");

    // R6: software reset
    frame(8'h35, 16'hC000);
    frame(8'h00, 16'h0003);
    check_outs("R6 software reset");
    frame(8'h00, 16'h0002);
    read_frame(8'h00, 16'h0002);
    frame(8'h00, 16'h0000);

    // R8: hardware reset arrives mid-word
    frame(8'h3B, 16'h0040);
    ser_en_n = 1'b0; cyc(4);
    begin
      logic [23:0] w;
      w = {8'h35, 16'h8000};
      for (int i = 0; i < 24; i++) begin
        if (i == 20) begin
          hw_rst = 1'b1;
          m_ro = 0; m_pf = 0; m_pp = 0; m_bw = 0; m_gain = 0;
        end
        send_bit(w[23-i], i, 0, 16'd0);
      end
    end
    close_window();
    gain_pin = 3'd3; ser_din = 1'b1; cyc(6);
    check_outs("R8 pin mode gain and bw");
    frame(8'h3B, 16'h0060);
    gain_pin = 3'd5; ser_din = 1'b0; cyc(6);
    check_outs("R8 serial ignored in pin mode");
    hw_rst = 1'b0; cyc(6);
    check_outs("R8 released, registers zero");

    // random mix
    void'($urandom(32'd1234));
    for (int k = 0; k < 40; k++) begin
      logic [7:0] a;
      logic [15:0] d;
      int sel;
      sel = int'($urandom % 4);
      a = (sel == 0) ? 8'h35 : (sel == 1) ? 8'h3B : (sel == 2) ? 8'h3B : 8'($urandom);
      d = 16'($urandom) & 16'hFFFE;
      pdn_pin = 1'($urandom);
      frame(a, d);
      if (m_ro) frame(8'h00, 16'h0000);
      check_outs("R5 R4 R9 random");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #900000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule